// File: doc/BRIEF.md
# Sign-Magnitude Shift-and-Add Multiplier

This block multiplies two 8-bit sign-magnitude numbers over several clock cycles. Bit 7 of each operand is the sign and bits 6..0 are the magnitude. When a start pulse is accepted, the multiplicand magnitude goes into a register whose bits are all visible at once. The multiplier magnitude goes into a shift register that hands out one bit per cycle, least significant bit first. In each iteration the current multiplier bit gates the whole multiplicand. The gated value is shifted left by the iteration index and added into a cleared 14-bit accumulator.

After seven iterations the sign of the product is resolved once: it is the XOR of the two operand signs, forced to 0 when the magnitude is zero. The result register loads a 16-bit sign-magnitude word and a done flag is raised for a single cycle. A controller with idle, load, iterate and done states sequences the work. A start pulse that arrives while an operation is running is dropped. A synchronous active-high reset returns everything to idle.

Top module: `smmul_core`

## Requirements
- R1: While reset is high and after it is released with no start pulse, `product` reads 0 and `done` reads 0.
- R2: `product[13:0]` equals the unsigned product of `op_a[6:0]` (multiplier) and `op_b[6:0]` (multiplicand), including the largest case 127 x 127 = 16129.
- R3: When the magnitude is nonzero, `product[15]` equals `op_a[7]` XOR `op_b[7]`.
- R4: When the magnitude is zero, `product[15]` is 0 whatever the operand signs are; a negative zero is never produced.
- R5: `product[14]` is always 0.
- R6: If `start` is sampled high at clock edge k while the block is idle, `done` is high for exactly one cycle, following edge k+9. `product` carries the new result from that same edge.
- R7: A `start` pulse sampled while an operation is in progress is ignored. The running result is unchanged and only one `done` pulse occurs.
- R8: Operands are sampled only at the edge that accepts `start`; changing `op_a` or `op_b` afterwards has no effect on the result.
- R9: `product` holds its value between completions, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication when idle |
| op_a | input | 8 | Multiplier, sign in bit 7, magnitude in bits 6..0 |
| op_b | input | 8 | Multiplicand, sign in bit 7, magnitude in bits 6..0 |
| product | output | 16 | Result: sign in bit 15, 0 in bit 14, magnitude in bits 13..0 |
| done | output | 1 | One-cycle pulse when `product` is updated |

## Verification
The bench targets operands with a zero magnitude but a set sign bit. A design that only XORs the signs would return a negative zero there. It also targets the 127 x 127 maximum, which a narrow accumulator or a dropped last iteration would truncate. A start pulse injected in mid-run would restart a careless controller, giving a late or doubled done pulse and a wrong result. Operands are scrambled right after acceptance and between runs, which exposes any design that reads its inputs live instead of from its load registers.

// File: rtl/smmul_pkg.sv
package smmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_ITER = 2'd2,
    ST_DONE = 2'd3
  } smmul_state_e;
endpackage

// File: rtl/smmul_ctrl.sv
module smmul_ctrl
  import smmul_pkg::*;
#(
  parameter int MAG_W = 7,
  localparam int CNT_W = (MAG_W > 1) ? $clog2(MAG_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             ld,
  output logic             clr,
  output logic             step,
  output logic             fin,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAG_W - 1);

  smmul_state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_LOAD;
        ST_LOAD: begin
          cnt   <= '0;
          state <= ST_ITER;
        end
        ST_ITER: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ld   = (state == ST_IDLE) && start;
  assign clr  = (state == ST_LOAD);
  assign step = (state == ST_ITER);
  assign fin  = (state == ST_DONE);

  // R7: a busy controller never goes back to loading
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> (state != ST_LOAD));

  // R6: iteration index stays within the magnitude width
  assert_iter_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ITER) |-> (cnt <= LAST));

  // R6: completion state lasts a single cycle
  assert_fin_single_R6: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);
endmodule

// File: rtl/smmul_shreg.sv
module smmul_shreg #(
  parameter int MAG_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [MAG_W-1:0] din,
  output logic             ser
);
  logic [MAG_W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {1'b0, q[MAG_W-1:1]};
  end

  assign ser = q[0];

  generate
    if (MAG_W > 1) begin : g_chk
      // R2: the next serial bit is the one above the bit just consumed
      assert_serial_order_R2: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> (ser == $past(q[1])));
    end
  endgenerate
endmodule

// File: rtl/smmul_datapath.sv
module smmul_datapath #(
  parameter int MAG_W = 7,
  localparam int OP_W   = MAG_W + 1,
  localparam int ACC_W  = 2 * MAG_W,
  localparam int PROD_W = 2 * OP_W,
  localparam int CNT_W  = (MAG_W > 1) ? $clog2(MAG_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic              clr,
  input  logic              step,
  input  logic              fin,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              ser,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic [PROD_W-1:0] product,
  output logic              done
);
  logic [MAG_W-1:0] mcand;
  logic             sgn_a, sgn_b;
  logic [ACC_W-1:0] acc;
  logic [MAG_W-1:0] partial;
  logic [ACC_W-1:0] addend;
  logic             res_sign;

  assign partial  = ser ? mcand : '0;
  assign addend   = {{(ACC_W-MAG_W){1'b0}}, partial} << cnt;
  assign res_sign = (sgn_a ^ sgn_b) && (acc != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand <= '0;
      sgn_a <= 1'b0;
      sgn_b <= 1'b0;
      acc   <= '0;
    end else begin
      if (ld) begin
        mcand <= op_b[MAG_W-1:0];
        sgn_a <= op_a[OP_W-1];
        sgn_b <= op_b[OP_W-1];
      end
      if (clr)       acc <= '0;
      else if (step) acc <= acc + addend;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      product <= '0;
      done    <= 1'b0;
    end else begin
      done <= fin;
      if (fin) product <= {res_sign, {(PROD_W-ACC_W-1){1'b0}}, acc};
    end
  end

  // R9: result register only moves on completion
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !fin |=> $stable(product));

  // R4: a set sign bit always comes with a nonzero magnitude
  assert_no_negzero_R4: assert property (@(posedge clk) disable iff (rst)
    product[PROD_W-1] |-> (product[ACC_W-1:0] != '0));

  // R6: done is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/smmul_core.sv
module smmul_core #(
  parameter int MAG_W = 7,
  localparam int OP_W   = MAG_W + 1,
  localparam int PROD_W = 2 * OP_W,
  localparam int CNT_W  = (MAG_W > 1) ? $clog2(MAG_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic [PROD_W-1:0] product,
  output logic              done
);
  logic             ld, clr, step, fin, ser;
  logic [CNT_W-1:0] cnt;

  smmul_ctrl #(.MAG_W(MAG_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .ld(ld), .clr(clr), .step(step), .fin(fin), .cnt(cnt)
  );

  smmul_shreg #(.MAG_W(MAG_W)) u_shreg (
    .clk(clk), .rst(rst), .load(ld), .shift(step),
    .din(op_a[MAG_W-1:0]), .ser(ser)
  );

  smmul_datapath #(.MAG_W(MAG_W)) u_dp (
    .clk(clk), .rst(rst), .ld(ld), .clr(clr), .step(step), .fin(fin),
    .cnt(cnt), .ser(ser), .op_a(op_a), .op_b(op_b),
    .product(product), .done(done)
  );
endmodule

// File: tb/test_smmul_core.sv
module test_smmul_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opa = '0;
  logic [7:0]  opb = '0;
  logic [15:0] product;
  logic        done;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  smmul_core i_smmul_core (
    .clk(clk), .rst(rst), .start(start), .op_a(opa), .op_b(opb),
    .product(product), .done(done)
  );

  function automatic logic [15:0] exp_prod(input logic [7:0] a, input logic [7:0] b);
    logic [13:0] m;
    logic        s;
    m = 14'(a[6:0]) * 14'(b[6:0]);
    s = (a[7] ^ b[7]) && (m != 0);
    return {s, 1'b0, m};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input bit poke);
    logic [15:0] e, p9;
    int seen, pulses;
    bit d10;
    string tag;
    e = exp_prod(a, b);
    seen = 0; pulses = 0; p9 = '0; d10 = 1'b0;
    @(negedge clk);
    opa = a; opb = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    opa = 8'($urandom); opb = 8'($urandom);   // R8: scramble after acceptance
    for (int i = 1; i <= 12; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (poke && i == 3) begin
        start = 1'b1; opa = 8'hFF; opb = 8'h7F;  // R7: start while busy
      end else begin
        start = 1'b0;
      end
      if (done) begin
        pulses++;
        if (seen == 0) seen = i;
      end
      if (i == 9)  p9 = product;
      if (i == 10) d10 = done;
    end
    if (e[13:0] == 0)   tag = "R4";
    else if (e[15])     tag = "R3";
    else                tag = "R2";
    check(seen == 9, poke ? "R7 done timing" : "R6 done timing", seen, 9);
    check(pulses == 1, poke ? "R7 pulse count" : "R6 pulse count", pulses, 1);
    check(!d10, "R6 done width", int'(d10), 0);
    check(p9 == e, poke ? "R7 result" : (a[7] != b[7] ? tag : {tag, " R8"}), int'(p9), int'(e));
    check(p9[14] == 1'b0, "R5 bit14", int'(p9[14]), 0);
  endtask

  task automatic hold_check();
    logic [15:0] ref_p;
    ref_p = product;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      opa = 8'($urandom); opb = 8'($urandom);
    end
    @(negedge clk);
    check(product == ref_p, "R9 hold", int'(product), int'(ref_p));
  endtask

  initial begin
    #(10 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(product == 16'h0 && done == 1'b0, "R1 during reset", int'(product), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(product == 16'h0 && done == 1'b0, "R1 after reset", int'(product), 0);

    run_op(8'h7F, 8'h7F, 1'b0);   // R2 max magnitude
    run_op(8'hFF, 8'hFF, 1'b0);   // R3 both negative -> positive
    run_op(8'hFF, 8'h01, 1'b0);   // R3 negative result
    run_op(8'h80, 8'h05, 1'b0);   // R4 negative zero suppressed
    run_op(8'h85, 8'h80, 1'b0);   // R4
    run_op(8'h00, 8'h00, 1'b0);
    run_op(8'h40, 8'hC1, 1'b0);   // top multiplier bit only
    hold_check();
    run_op(8'h83, 8'h25, 1'b1);   // R7 start while busy
    hold_check();
    for (int k = 0; k < 40; k++) begin
      run_op(8'($urandom), 8'($urandom), (k % 7) == 3);
      if ((k % 10) == 0) hold_check();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule